// File: doc/BRIEF.md
# Radix-16 Sequential Integer Divider

This block divides one unsigned 32-bit integer by another and returns both the quotient and the remainder. A client pulses `start` with the two operands while the block is idle. The block raises `busy` and works for a fixed number of cycles. It then pulses `done` for one cycle, with `quotient` and `remainder` valid. Both outputs hold their value until the next completion. A zero divisor is caught when the request is accepted. It sets `div_zero` and completes on the next clock edge without any iterations.

Inside, a normalization cycle shifts the divisor left until its top bit is set and shifts the dividend by the same amount. It also offsets the partial remainder by half a divisor so the recurrence starts inside its convergence bound. The iterative core keeps the partial remainder as a sum/carry pair. Each clock it performs two chained radix-4 steps with digits in {-2,-1,0,1,2}, with the remainder shifted left by two bits between them, so it retires four quotient bits per cycle. Each step picks its digit from a short carry-propagate estimate of the top remainder bits. The estimate is compared against thresholds derived from the top six bits of the normalized divisor. A final cycle does four things:
- it merges the positive and negative digit registers with one subtraction;
- it resolves the remainder with one carry-propagate add;
- if that remainder is negative, it adds the divisor back once and subtracts one from the quotient;
- it shifts the remainder right to undo the normalization.

Top module: `srt_divider`

## Requirements
- R1: For a nonzero divisor b and any dividend a, the completed result satisfies quotient = floor(a/b) and remainder = a - b*quotient, with remainder < b.
- R2: For a nonzero divisor, `done` goes high in the cycle after the tenth rising clock edge that follows the edge accepting `start`. That is one normalization cycle, eight iteration cycles and one finishing cycle.
- R3: `busy` is high in every cycle from the edge after an accepted nonzero-divisor start until the edge that raises `done`, and is low whenever `done` is high.
- R4: A start with divisor 0 is completed at the accepting edge. `done` and `div_zero` are high in the next cycle, `quotient` is all ones, `remainder` equals the dividend, and `busy` stays low.
- R5: A `start` pulse while `busy` is high is ignored. The running division finishes with its own operands and latency, and no extra `done` follows.
- R6: `done` lasts one cycle per completion, and `quotient`, `remainder` and `div_zero` hold their values until the next completion.
- R7: Completion of a division with a nonzero divisor clears `div_zero`.
- R8: While reset is asserted and after its release, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all zero until the first completion.
- R9: Every selected quotient digit lies in {-2..2}, and the carry-save partial remainder stays within its three-sign-bit range throughout the iterations.
- R10: A new `start` presented in the same cycle that `done` is high is accepted, and its result arrives with the normal latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a division; accepted only while idle |
| dividend | input | 32 | Unsigned dividend, sampled with start |
| divisor | input | 32 | Unsigned divisor, sampled with start |
| busy | output | 1 | A nonzero-divisor division is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| div_zero | output | 1 | Last completed request had a zero divisor |
| quotient | output | 32 | Unsigned quotient of the last completed request |
| remainder | output | 32 | Unsigned remainder of the last completed request |

## Verification
Completion and acceptance can coincide. The cycle that carries a `done` pulse is also an idle cycle, so a new `start` can land in that same cycle. The bench drives a fresh request exactly on the sampled `done` of the previous one. It checks that the old results were valid at that moment and that the new request still takes ten edges and returns its own quotient and remainder. In a second scenario a start arrives while the core is still iterating. That result must match the first operand pair, with no stray completion.

// File: rtl/srt_div_pkg.sv
package srt_div_pkg;
  // width of the carry-propagate remainder estimate fed to digit selection
  localparam int EST_W = 10;
  // divisor bits that index the selection thresholds
  localparam int DTOP_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_ITER = 2'd2,
    ST_FIN  = 2'd3
  } div_state_e;
endpackage

// File: rtl/srt_norm.sv
// Pre-processing: leading-zero count of the divisor, alignment of both
// operands, and the initial partial remainder (shifted dividend minus half
// the normalized divisor) so the recurrence starts within bound.
module srt_norm #(
  parameter int W = 32,
  localparam int RW = 2 * W + 4,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  dvd,
  input  logic [W-1:0]  dvs,
  output logic [W-1:0]  dvs_n,
  output logic [SW-1:0] shamt,
  output logic [RW-1:0] rem0
);
  logic [2*W-1:0] dvd_sh;
  logic           found;

  always_comb begin
    shamt = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && dvs[i]) begin
        shamt = SW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end

  assign dvs_n  = dvs << shamt;
  assign dvd_sh = {{W{1'b0}}, dvd} << shamt;
  assign rem0   = {4'b0000, dvd_sh} - {5'b00000, dvs_n, {(W-1){1'b0}}};
endmodule

// File: rtl/srt_qsel.sv
// Radix-4 digit selection. Thresholds sit at 0.5 and 1.5 times the truncated
// divisor; they are computed from the divisor top bits, not stored.
module srt_qsel
  import srt_div_pkg::*;
(
  input  logic [EST_W-1:0]  est,
  input  logic [DTOP_W-1:0] dtop,
  output logic signed [2:0] dig
);
  logic signed [EST_W+1:0] e2, d1, d3;

  always_comb begin
    e2 = $signed({est[EST_W-1], est, 1'b0});
    d1 = $signed({{(EST_W+2-DTOP_W){1'b0}}, dtop});
    d3 = d1 + (d1 <<< 1);
    if (e2 >= d3)       dig = 3'sd2;
    else if (e2 >= d1)  dig = 3'sd1;
    else if (e2 >= -d1) dig = 3'sd0;
    else if (e2 >= -d3) dig = -3'sd1;
    else                dig = -3'sd2;
  end
endmodule

// File: rtl/srt_step.sv
// One radix-4 step on a carry-save remainder: shift by two, estimate,
// select a digit, then a 3:2 compression with the chosen divisor multiple.
module srt_step
  import srt_div_pkg::*;
#(
  parameter int W = 32,
  localparam int RW = 2 * W + 4
) (
  input  logic [RW-1:0]     s_in,
  input  logic [RW-1:0]     c_in,
  input  logic [W-1:0]      dvs_n,
  output logic [RW-1:0]     s_out,
  output logic [RW-1:0]     c_out,
  output logic signed [2:0] dig
);
  logic [RW-1:0]    s4, c4, d1x, d2x, mag, addend, maj;
  logic [EST_W-1:0] est;
  logic             inj;
  logic             unused_step;

  assign s4  = {s_in[RW-3:0], 2'b00};
  assign c4  = {c_in[RW-3:0], 2'b00};
  assign est = s4[RW-1 -: EST_W] + c4[RW-1 -: EST_W];
  assign d1x = {4'b0000, dvs_n, {W{1'b0}}};
  assign d2x = {3'b000, dvs_n, {(W+1){1'b0}}};

  srt_qsel u_qsel (
    .est  (est),
    .dtop (dvs_n[W-1 -: DTOP_W]),
    .dig  (dig)
  );

  always_comb begin
    mag = (dig == 3'sd2 || dig == -3'sd2) ? d2x : d1x;
    if (dig > 3'sd0) begin
      addend = ~mag;
      inj    = 1'b1;
    end else if (dig < 3'sd0) begin
      addend = mag;
      inj    = 1'b0;
    end else begin
      addend = '0;
      inj    = 1'b0;
    end
  end

  assign maj         = (s4 & c4) | (s4 & addend) | (c4 & addend);
  assign s_out       = s4 ^ c4 ^ addend;
  assign c_out       = {maj[RW-2:0], inj};
  assign unused_step = ^{s_in[RW-1:RW-2], c_in[RW-1:RW-2], maj[RW-1]};
endmodule

// File: rtl/srt_divider.sv
module srt_divider
  import srt_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int RW    = 2 * W + 4;
  localparam int SW    = $clog2(W);
  localparam int ITERS = W / 4;
  localparam int CW    = $clog2(ITERS);
  localparam int STEPS = 2;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  div_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  dvd_q, dvd_d, dvs_q, dvs_d;
  logic [SW-1:0] sh_q, sh_d;
  logic [RW-1:0] s_q, s_d, c_q, c_d;
  logic [W-1:0]  qp_q, qp_d, qn_q, qn_d;
  logic [W-1:0]  quot_q, quot_d, rem_q, rem_d;
  logic          done_q, done_d, dz_q, dz_d;
  logic          op_en, rem_en, out_en;

  // pre-processing
  logic [W-1:0]  nrm_dvs;
  logic [SW-1:0] nrm_sh;
  logic [RW-1:0] nrm_rem;
  srt_norm #(.W(W)) u_norm (
    .dvd   (dvd_q),
    .dvs   (dvs_q),
    .dvs_n (nrm_dvs),
    .shamt (nrm_sh),
    .rem0  (nrm_rem)
  );

  // iterative core: STEPS chained radix-4 steps per clock
  logic [RW-1:0]     s_ch [0:STEPS];
  logic [RW-1:0]     c_ch [0:STEPS];
  logic signed [2:0] dig_ch [0:STEPS-1];
  assign s_ch[0] = s_q;
  assign c_ch[0] = c_q;
  for (genvar g = 0; g < STEPS; g++) begin : g_step
    srt_step #(.W(W)) u_step (
      .s_in  (s_ch[g]),
      .c_in  (c_ch[g]),
      .dvs_n (dvs_q),
      .s_out (s_ch[g+1]),
      .c_out (c_ch[g+1]),
      .dig   (dig_ch[g])
    );
  end

  function automatic logic [1:0] pos_mag(input logic signed [2:0] d);
    return (d > 3'sd0) ? d[1:0] : 2'b00;
  endfunction
  function automatic logic [1:0] neg_mag(input logic signed [2:0] d);
    logic [2:0] t;
    t = -d;
    return (d < 3'sd0) ? t[1:0] : 2'b00;
  endfunction

  // post-processing
  logic [RW-1:0] wsum, rfix, dvs_x;
  logic [W-1:0]  qraw, rnorm;
  logic          wneg;
  assign wsum  = s_q + c_q;
  assign wneg  = wsum[RW-1];
  assign dvs_x = {4'b0000, dvs_q, {W{1'b0}}};
  assign rfix  = wneg ? wsum + dvs_x : wsum;
  assign qraw  = qp_q - qn_q + {1'b1, {(W-1){1'b0}}};
  assign rnorm = rfix[2*W-1:W];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dvd_d   = dvd_q;
    dvs_d   = dvs_q;
    sh_d    = sh_q;
    s_d     = s_q;
    c_d     = c_q;
    qp_d    = qp_q;
    qn_d    = qn_q;
    quot_d  = quot_q;
    rem_d   = rem_q;
    dz_d    = dz_q;
    done_d  = 1'b0;
    op_en   = 1'b0;
    rem_en  = 1'b0;
    out_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        if (divisor == '0) begin
          out_en = 1'b1;
          done_d = 1'b1;
          dz_d   = 1'b1;
          quot_d = '1;
          rem_d  = dividend;
        end else begin
          op_en   = 1'b1;
          dvd_d   = dividend;
          dvs_d   = divisor;
          state_d = ST_NORM;
        end
      end
      ST_NORM: begin
        op_en   = 1'b1;
        rem_en  = 1'b1;
        dvs_d   = nrm_dvs;
        sh_d    = nrm_sh;
        s_d     = nrm_rem;
        c_d     = '0;
        qp_d    = '0;
        qn_d    = '0;
        cnt_d   = '0;
        state_d = ST_ITER;
      end
      ST_ITER: begin
        rem_en = 1'b1;
        s_d    = s_ch[STEPS];
        c_d    = c_ch[STEPS];
        qp_d   = {qp_q[W-5:0], pos_mag(dig_ch[0]), pos_mag(dig_ch[1])};
        qn_d   = {qn_q[W-5:0], neg_mag(dig_ch[0]), neg_mag(dig_ch[1])};
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN: begin
        out_en  = 1'b1;
        done_d  = 1'b1;
        dz_d    = 1'b0;
        quot_d  = qraw - W'(wneg);
        rem_d   = rnorm >> sh_q;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      dvd_q   <= '0;
      dvs_q   <= '0;
      sh_q    <= '0;
      s_q     <= '0;
      c_q     <= '0;
      qp_q    <= '0;
      qn_q    <= '0;
      quot_q  <= '0;
      rem_q   <= '0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (op_en) begin
        dvd_q <= dvd_d;
        dvs_q <= dvs_d;
        sh_q  <= sh_d;
      end
      if (rem_en) begin
        cnt_q <= cnt_d;
        s_q   <= s_d;
        c_q   <= c_d;
        qp_q  <= qp_d;
        qn_q  <= qn_d;
      end
      if (out_en) begin
        quot_q <= quot_d;
        rem_q  <= rem_d;
        dz_q   <= dz_d;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign div_zero  = dz_q;
  assign quotient  = quot_q;
  assign remainder = rem_q;

  // ---------------- assertions ----------------
  p_rem_exact_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_FIN) |-> (rfix[W-1:0] == '0 && rfix[RW-1:2*W] == '0 && rnorm < dvs_q));

  p_fin_after_iter_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_FIN) |-> ($past(state_q) == ST_ITER && $past(cnt_q) == LAST));

  p_norm_to_iter_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_NORM) |=> (state_q == ST_ITER && cnt_q == '0));

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !busy);

  p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && !busy && divisor == '0) |=> (done && div_zero && quotient == '1 && !busy));

  p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && start) |=> $stable(dvd_q));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && !(start && divisor == '0)) |=> !done);

  p_dz_clear_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_FIN) |=> (done && !div_zero));

  p_digit_range_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_ITER) |-> (dig_ch[0] >= -3'sd2 && dig_ch[0] <= 3'sd2 &&
                              dig_ch[1] >= -3'sd2 && dig_ch[1] <= 3'sd2));

  p_rem_bound_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_ITER) |-> (wsum[RW-1:RW-3] == 3'b000 || wsum[RW-1:RW-3] == 3'b111));
endmodule

// File: tb/srt_divider_test.sv
module srt_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, div_zero;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] rs = 32'h1234_5678;

  srt_divider uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .div_zero(div_zero),
    .quotient(quotient), .remainder(remainder)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // called at a negedge: request accepted at the next posedge; returns at
  // the negedge where done is seen, lat = edges after the accepting edge
  task automatic issue(input logic [31:0] a, input logic [31:0] b, output int lat);
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input logic [31:0] a, input logic [31:0] b, input int lat, input string tag);
    chk(done == 1'b1, {tag, " R2 done seen"}, done, 1);
    chk(lat == 10, {tag, " R2 latency"}, lat, 10);
    chk(quotient == a / b, {tag, " R1 quotient"}, quotient, a / b);
    chk(remainder == a % b, {tag, " R1 remainder"}, remainder, a % b);
    chk(div_zero == 1'b0, {tag, " R7 div_zero clear"}, div_zero, 0);
  endtask

  task automatic t_reset;
    chk(busy == 0 && done == 0 && div_zero == 0, "R8 reset flags", {busy, done, div_zero}, 0);
    chk(quotient == 0 && remainder == 0, "R8 reset data", {quotient, remainder}, 0);
  endtask

  task automatic t_one(input logic [31:0] a, input logic [31:0] b);
    int lat;
    @(negedge clk);
    issue(a, b, lat);
    check_result(a, b, lat, "directed");
  endtask

  task automatic t_busy_window;
    int lat;
    bit seen_busy;
    @(negedge clk);
    start = 1'b1; dividend = 32'd1000; divisor = 32'd33;
    @(negedge clk);
    start = 1'b0;
    seen_busy = 1'b1;
    lat = 0;
    while (!done && lat < 40) begin
      if (!busy) seen_busy = 1'b0;
      @(negedge clk);
      lat++;
    end
    chk(seen_busy, "R3 busy held while working", seen_busy, 1);
    chk(busy == 1'b0, "R3 busy low with done", busy, 0);
    check_result(32'd1000, 32'd33, lat, "busy window");
  endtask

  task automatic t_div_zero;
    int lat;
    @(negedge clk);
    issue(32'hCAFE_0001, 32'd0, lat);
    chk(lat == 0, "R4 zero divisor latency", lat, 0);
    chk(div_zero == 1'b1, "R4 div_zero set", div_zero, 1);
    chk(quotient == 32'hFFFF_FFFF, "R4 quotient all ones", quotient, 32'hFFFF_FFFF);
    chk(remainder == 32'hCAFE_0001, "R4 remainder is dividend", remainder, 32'hCAFE_0001);
    chk(busy == 1'b0, "R4 not busy", busy, 0);
    @(negedge clk);
    chk(div_zero == 1'b1, "R6 div_zero holds", div_zero, 1);
    chk(done == 1'b0, "R6 done single cycle", done, 0);
    t_one(32'd77, 32'd7); // clears div_zero (R7)
  endtask

  task automatic t_busy_ignore;
    int lat;
    bit extra;
    @(negedge clk);
    start = 1'b1; dividend = 32'hFFFF_0000; divisor = 32'd3;
    @(negedge clk);
    lat = 0;
    dividend = 32'd5; divisor = 32'd0;
    @(negedge clk);
    lat++;
    dividend = 32'd9; divisor = 32'd4;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check_result(32'hFFFF_0000, 32'd3, lat, "R5 ignored start");
    extra = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done) extra = 1'b1;
    end
    chk(!extra, "R5 no extra done", extra, 0);
  endtask

  task automatic t_hold;
    int lat;
    @(negedge clk);
    issue(32'd123456789, 32'd1000, lat);
    check_result(32'd123456789, 32'd1000, lat, "hold");
    dividend = 32'd1; divisor = 32'd1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R6 done low after pulse", done, 0);
      chk(quotient == 32'd123456 && remainder == 32'd789, "R6 outputs hold",
          {quotient, remainder}, {32'd123456, 32'd789});
    end
  endtask

  task automatic t_back_to_back;
    int lat;
    @(negedge clk);
    issue(32'hDEAD_BEEF, 32'h1234, lat);
    check_result(32'hDEAD_BEEF, 32'h1234, lat, "b2b first");
    issue(32'h8000_0000, 32'd3, lat);
    check_result(32'h8000_0000, 32'd3, lat, "R10 b2b second");
    issue(32'd99, 32'd0, lat);
    chk(lat == 0 && div_zero && remainder == 32'd99, "R10 zero after done", lat, 0);
  endtask

  task automatic t_random(input int n);
    int lat;
    logic [31:0] a, b;
    for (int i = 0; i < n; i++) begin
      rs = nxt(rs); a = rs;
      rs = nxt(rs); b = rs >> (rs[4:0]);
      if (b == 0) b = 32'd1;
      @(negedge clk);
      issue(a, b, lat);
      check_result(a, b, lat, "R1 random");
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WDOG_LIMIT) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_one(32'd100, 32'd7);
    t_one(32'hFFFF_FFFF, 32'd1);
    t_one(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_one(32'd5, 32'd10);
    t_one(32'd0, 32'd5);
    t_one(32'd12345678, 32'h8000_0000);
    t_one(32'hFFFF_FFFE, 32'hFFFF_FFFF);
    t_one(32'd1, 32'd1);
    t_one(32'h7FFF_FFFF, 32'd2);
    t_busy_window;
    t_div_zero;
    t_busy_ignore;
    t_hold;
    t_back_to_back;
    t_random(300);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule